// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the byte-wide execution unit of a small 16-bit processor datapath. Each cycle in which `in_valid` is high it takes a 4-bit operation code, a source byte, a destination byte and the current status word. It computes the byte result, decides whether the destination is to be written, and builds the next status word from the carry, zero, negative and overflow flags. Every result leaves through one register stage, so each operation appears on the outputs one clock after it is presented.

Arithmetic, compare and logic operations share one adder and one logic unit. A small decoder chooses which of them feeds the result and which flag rules apply. Operations that must not disturb the flags pass the incoming status word through untouched. Decimal add is accepted and does nothing. Codes 0 to 3 are flagged as illegal.

Top module: `byte_flag_alu`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` one cycle later, and `dst_we` and `illegal_op` are high only in a cycle where `out_valid` is high. Reset clears `out_valid`, `dst_we`, `illegal_op`, `res_val` and `stat_out` to zero.
- R2: Codes 0 to 3 are illegal. They give `illegal_op`=1, `dst_we`=0, `res_val`=0 and `stat_out` equal to the incoming status word.
- R3: Status bit positions are carry 0, zero 1, negative 2 and overflow 8. Code 5 (add) gives dst+src, and code 6 (add with carry) gives dst+src+carry-in (status bit 0). Carry is the carry out of bit 7. Overflow is set when both operands have the same sign and the result sign differs. Negative is result bit 7, and zero means the 8-bit result is 0.
- R4: Code 8 (subtract) and code 9 (compare) compute dst + ~src + 1. Code 7 (subtract with carry) computes dst + ~src + carry-in. Carry is the carry out of bit 7, so 1 means no borrow. Overflow is set when the operand signs differ and the result sign differs from the sign of dst. N and Z follow R3.
- R5: Code 9 (compare) and code 11 (bit test) update the flags but never assert `dst_we`. Their computed value still appears on `res_val`.
- R6: Code 4 (copy: result = src), code 12 (clear bits: dst AND NOT src) and code 13 (set bits: dst OR src) assert `dst_we` and leave `stat_out` equal to the incoming status word.
- R7: Code 11 (bit test: dst AND src), code 15 (AND) and code 14 (XOR) set N from result bit 7, set Z when the result is 0, and set C to NOT Z. Overflow is cleared for AND and bit test. For XOR, overflow is set only when bit 7 of both operands is 1.
- R8: Code 10 (decimal add) is legal but gives `dst_we`=0, `res_val`=0, `illegal_op`=0 and an unchanged status word.
- R9: Status bits other than 0, 1, 2 and 8 pass through to `stat_out` unchanged for every operation.
- R10: `dst_we` is asserted for codes 4, 5, 6, 7, 8, 12, 13, 14 and 15 and for no other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_code | input | 4 | Operation select |
| src_val | input | 8 | Source operand |
| dst_val | input | 8 | Destination operand |
| stat_in | input | 16 | Current status word |
| out_valid | output | 1 | Registered result valid |
| res_val | output | 8 | Registered result byte |
| dst_we | output | 1 | Destination write enable |
| stat_out | output | 16 | Next status word |
| illegal_op | output | 1 | Operation code was illegal |

## Verification
The bench uses the default widths: an 8-bit data path and a 16-bit status word. At these widths the carry out of bit 7, the signed overflow boundaries at 0x7F/0x80 and the wrap to zero can all be reached with single hand-picked vectors. The 16-bit status word also leaves bits 3 to 7 and 9 to 15 free, and the bench fills them with non-zero patterns to show that they pass through each flag-updating operation.

// File: rtl/balu_pkg.sv
package balu_pkg;

  typedef enum logic [3:0] {
    OP_COPY = 4'd4,
    OP_ADD  = 4'd5,
    OP_ADDC = 4'd6,
    OP_SUBC = 4'd7,
    OP_SUB  = 4'd8,
    OP_CMP  = 4'd9,
    OP_DEC  = 4'd10,
    OP_TEST = 4'd11,
    OP_CLR  = 4'd12,
    OP_SET  = 4'd13,
    OP_XOR  = 4'd14,
    OP_AND  = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    RS_NONE  = 2'd0,
    RS_ARITH = 2'd1,
    RS_LOGIC = 2'd2
  } res_src_e;

  typedef enum logic [2:0] {
    LG_PASS = 3'd0,
    LG_AND  = 3'd1,
    LG_ANDN = 3'd2,
    LG_OR   = 3'd3,
    LG_XOR  = 3'd4
  } logic_sel_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef struct packed {
    res_src_e   src;
    logic_sel_e lsel;
    logic       inv_b;
    cin_sel_e   cin;
    logic       we;
    logic       upd;
    logic       xor_v;
    logic       bad;
  } ctrl_t;

  // Status bit positions, decoded by the surrounding datapath
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 8;

endpackage

// File: rtl/balu_decode.sv
module balu_decode
  import balu_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W-1:0] op,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl       = '0;
    ctrl.src   = RS_NONE;
    ctrl.lsel  = LG_PASS;
    ctrl.cin   = CIN_ZERO;
    case (op)
      OP_COPY: begin ctrl.src = RS_LOGIC; ctrl.lsel = LG_PASS; ctrl.we = 1'b1; end
      OP_ADD:  begin ctrl.src = RS_ARITH; ctrl.we = 1'b1; ctrl.upd = 1'b1; end
      OP_ADDC: begin ctrl.src = RS_ARITH; ctrl.cin = CIN_FLAG; ctrl.we = 1'b1; ctrl.upd = 1'b1; end
      OP_SUBC: begin
        ctrl.src = RS_ARITH; ctrl.inv_b = 1'b1; ctrl.cin = CIN_FLAG;
        ctrl.we = 1'b1; ctrl.upd = 1'b1;
      end
      OP_SUB:  begin
        ctrl.src = RS_ARITH; ctrl.inv_b = 1'b1; ctrl.cin = CIN_ONE;
        ctrl.we = 1'b1; ctrl.upd = 1'b1;
      end
      OP_CMP:  begin
        ctrl.src = RS_ARITH; ctrl.inv_b = 1'b1; ctrl.cin = CIN_ONE; ctrl.upd = 1'b1;
      end
      OP_DEC:  ctrl.src = RS_NONE;
      OP_TEST: begin ctrl.src = RS_LOGIC; ctrl.lsel = LG_AND; ctrl.upd = 1'b1; end
      OP_CLR:  begin ctrl.src = RS_LOGIC; ctrl.lsel = LG_ANDN; ctrl.we = 1'b1; end
      OP_SET:  begin ctrl.src = RS_LOGIC; ctrl.lsel = LG_OR; ctrl.we = 1'b1; end
      OP_XOR:  begin
        ctrl.src = RS_LOGIC; ctrl.lsel = LG_XOR; ctrl.we = 1'b1;
        ctrl.upd = 1'b1; ctrl.xor_v = 1'b1;
      end
      OP_AND:  begin ctrl.src = RS_LOGIC; ctrl.lsel = LG_AND; ctrl.we = 1'b1; ctrl.upd = 1'b1; end
      default: ctrl.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/balu_arith.sv
module balu_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              inv_b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);

  localparam int MSB = DATA_W - 1;

  // Full-width sum with carry out in the top bit
  function automatic logic [DATA_W:0] add_c(input logic [DATA_W-1:0] x,
                                            input logic [DATA_W-1:0] y,
                                            input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  endfunction

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = inv_b ? ~b : b;
  assign wide  = add_c(a, b_eff, cin);
  assign sum   = wide[MSB:0];
  assign cout  = wide[DATA_W];
  // Same-sign addends giving the opposite sign; with b inverted this is the
  // subtract rule (signs differ, result sign differs from a)
  assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/balu_logic.sv
module balu_logic
  import balu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic_sel_e        sel,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    case (sel)
      LG_AND:  res = a & b;
      LG_ANDN: res = a & ~b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = b;
    endcase
  end

endmodule

// File: rtl/byte_flag_alu.sv
module byte_flag_alu
  import balu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SR_W   = 16,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [SR_W-1:0]   stat_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_val,
  output logic              dst_we,
  output logic [SR_W-1:0]   stat_out,
  output logic              illegal_op
);

  localparam int MSB = DATA_W - 1;
  localparam logic [SR_W-1:0] FLAG_MASK =
    (SR_W'(1) << FLG_C) | (SR_W'(1) << FLG_Z) | (SR_W'(1) << FLG_N) | (SR_W'(1) << FLG_V);

  ctrl_t             ctrl;
  logic              cin_bit;
  logic [DATA_W-1:0] arith_sum;
  logic              arith_cout;
  logic              arith_ovf;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] res_n;
  logic              flag_c, flag_z, flag_n, flag_v;
  logic [SR_W-1:0]   stat_n;

  balu_decode #(.OPC_W(OPC_W)) u_dec (
    .op   (op_code),
    .ctrl (ctrl)
  );

  always_comb begin
    case (ctrl.cin)
      CIN_ONE:  cin_bit = 1'b1;
      CIN_FLAG: cin_bit = stat_in[FLG_C];
      default:  cin_bit = 1'b0;
    endcase
  end

  balu_arith #(.DATA_W(DATA_W)) u_arith (
    .a     (dst_val),
    .b     (src_val),
    .inv_b (ctrl.inv_b),
    .cin   (cin_bit),
    .sum   (arith_sum),
    .cout  (arith_cout),
    .ovf   (arith_ovf)
  );

  balu_logic #(.DATA_W(DATA_W)) u_logic (
    .a   (dst_val),
    .b   (src_val),
    .sel (ctrl.lsel),
    .res (logic_res)
  );

  always_comb begin
    case (ctrl.src)
      RS_ARITH: res_n = arith_sum;
      RS_LOGIC: res_n = logic_res;
      default:  res_n = '0;
    endcase
  end

  assign flag_z = (res_n == '0);
  assign flag_n = res_n[MSB];
  assign flag_c = (ctrl.src == RS_ARITH) ? arith_cout : ~flag_z;
  assign flag_v = (ctrl.src == RS_ARITH) ? arith_ovf
                                         : (ctrl.xor_v & dst_val[MSB] & src_val[MSB]);

  always_comb begin
    stat_n = stat_in;
    if (ctrl.upd) begin
      stat_n[FLG_C] = flag_c;
      stat_n[FLG_Z] = flag_z;
      stat_n[FLG_N] = flag_n;
      stat_n[FLG_V] = flag_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      dst_we     <= 1'b0;
      illegal_op <= 1'b0;
      res_val    <= '0;
      stat_out   <= '0;
    end else begin
      out_valid  <= in_valid;
      dst_we     <= in_valid & ctrl.we;
      illegal_op <= in_valid & ctrl.bad;
      if (in_valid) begin
        res_val  <= res_n;
        stat_out <= stat_n;
      end
    end
  end

  // R1: valid follows input by one cycle; side outputs only with valid
  p_valid_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_we_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we || illegal_op) |-> out_valid);

  // R2: illegal codes write nothing and keep status
  p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code < OPC_W'(4)) |=> (illegal_op && !dst_we && stat_out == $past(stat_in)));

  // R5: compare and bit test never write
  p_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_code == OPC_W'(OP_CMP) || op_code == OPC_W'(OP_TEST))) |=> !dst_we);

  // R6: copy / clear / set keep the status word
  p_stat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_code == OPC_W'(OP_COPY) || op_code == OPC_W'(OP_CLR) ||
                  op_code == OPC_W'(OP_SET))) |=> (dst_we && stat_out == $past(stat_in)));

  // R7: logic ops report carry as result-nonzero
  p_logic_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_code == OPC_W'(OP_TEST) || op_code == OPC_W'(OP_AND) ||
                  op_code == OPC_W'(OP_XOR))) |=> (stat_out[FLG_C] == (res_val != '0)));

  // R9: non-flag status bits always pass through
  p_upper_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((stat_out & ~FLAG_MASK) == $past(stat_in & ~FLAG_MASK)));

  // R3: adder overflow only with equal-sign addends (internal wires)
  p_ovf_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_ovf && !ctrl.inv_b) |-> (dst_val[MSB] == src_val[MSB]));

endmodule

// File: tb/tb_byte_flag_alu.sv
module tb_byte_flag_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [7:0]  src_val = '0;
  logic [7:0]  dst_val = '0;
  logic [15:0] stat_in = '0;
  logic        out_valid;
  logic [7:0]  res_val;
  logic        dst_we;
  logic [15:0] stat_out;
  logic        illegal_op;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  byte_flag_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_val(src_val), .dst_val(dst_val), .stat_in(stat_in),
    .out_valid(out_valid), .res_val(res_val), .dst_we(dst_we),
    .stat_out(stat_out), .illegal_op(illegal_op)
  );

  // {op, src, dst, stat_in, res, we, illegal, stat_out}
  // status: C=0x0001 Z=0x0002 N=0x0004 V=0x0100
  localparam int NV = 19;
  localparam logic [61:0] VEC [NV] = '{
    {4'd4,  8'hA5, 8'h3C, 16'h0107, 8'hA5, 1'b1, 1'b0, 16'h0107}, // R6 copy
    {4'd5,  8'h7F, 8'h01, 16'h0000, 8'h80, 1'b1, 1'b0, 16'h0104}, // R3 pos overflow
    {4'd5,  8'hFF, 8'h01, 16'h0000, 8'h00, 1'b1, 1'b0, 16'h0003}, // R3 wrap carry
    {4'd6,  8'h10, 8'h20, 16'h0001, 8'h31, 1'b1, 1'b0, 16'h0000}, // R3 carry in
    {4'd6,  8'h80, 8'h80, 16'h0000, 8'h00, 1'b1, 1'b0, 16'h0103}, // R3 neg overflow
    {4'd7,  8'h01, 8'h05, 16'h0000, 8'h03, 1'b1, 1'b0, 16'h0001}, // R4 subc C=0
    {4'd7,  8'h05, 8'h05, 16'h0001, 8'h00, 1'b1, 1'b0, 16'h0003}, // R4 subc C=1
    {4'd8,  8'h05, 8'h03, 16'hFEF8, 8'hFE, 1'b1, 1'b0, 16'hFEFC}, // R4/R9 borrow
    {4'd8,  8'h01, 8'h80, 16'h0000, 8'h7F, 1'b1, 1'b0, 16'h0101}, // R4 overflow
    {4'd9,  8'h42, 8'h42, 16'h0104, 8'h00, 1'b0, 1'b0, 16'h0003}, // R5 compare
    {4'd10, 8'h12, 8'h34, 16'h0005, 8'h00, 1'b0, 1'b0, 16'h0005}, // R8 dec add
    {4'd11, 8'h0F, 8'hF1, 16'h0100, 8'h01, 1'b0, 1'b0, 16'h0001}, // R7 bit test
    {4'd11, 8'h0F, 8'hF0, 16'h0005, 8'h00, 1'b0, 1'b0, 16'h0002}, // R7 bit zero
    {4'd12, 8'h0F, 8'hFF, 16'h0102, 8'hF0, 1'b1, 1'b0, 16'h0102}, // R6 clear
    {4'd13, 8'h0F, 8'h30, 16'h0004, 8'h3F, 1'b1, 1'b0, 16'h0004}, // R6 set
    {4'd14, 8'h80, 8'h81, 16'h0000, 8'h01, 1'b1, 1'b0, 16'h0101}, // R7 xor V
    {4'd14, 8'h55, 8'h55, 16'hA800, 8'h00, 1'b1, 1'b0, 16'hA802}, // R7/R9 xor zero
    {4'd15, 8'hF0, 8'h8F, 16'h0100, 8'h80, 1'b1, 1'b0, 16'h0005}, // R7 and
    {4'd2,  8'h11, 8'h22, 16'h1234, 8'h00, 1'b0, 1'b1, 16'h1234}  // R2 illegal
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] s, input logic [7:0] d,
                       input logic [15:0] sr);
    @(negedge clk);
    op_code  = op;
    src_val  = s;
    dst_val  = d;
    stat_in  = sr;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset out_valid", 32'(out_valid), 0);
    chk("R1 reset dst_we", 32'(dst_we), 0);
    chk("R1 reset res_val", 32'(res_val), 0);
    chk("R1 reset stat_out", 32'(stat_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle out_valid", 32'(out_valid), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_code  = VEC[i][61:58];
      src_val  = VEC[i][57:50];
      dst_val  = VEC[i][49:42];
      stat_in  = VEC[i][41:26];
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R1 vec%0d out_valid", i), 32'(out_valid), 1);
      chk($sformatf("R3/R4/R7 vec%0d res_val", i), 32'(res_val), 32'(VEC[i][25:18]));
      chk($sformatf("R10 vec%0d dst_we", i), 32'(dst_we), 32'(VEC[i][17]));
      chk($sformatf("R2 vec%0d illegal_op", i), 32'(illegal_op), 32'(VEC[i][16]));
      chk($sformatf("R9 vec%0d stat_out", i), 32'(stat_out), 32'(VEC[i][15:0]));
      in_valid = 1'b0;
    end

    // R1: with in_valid low, valid, write and illegal drop one cycle later
    @(negedge clk);
    chk("R1 drop out_valid", 32'(out_valid), 0);
    chk("R1 drop dst_we", 32'(dst_we), 0);
    chk("R1 drop illegal_op", 32'(illegal_op), 0);

    // R2: every illegal code 0..3
    for (int c = 0; c < 4; c++) begin
      apply(4'(c), 8'hFF, 8'h01, 16'h5A5A);
      chk("R2 low code illegal", 32'(illegal_op), 1);
      chk("R2 low code we", 32'(dst_we), 0);
      chk("R2 low code stat", 32'(stat_out), 32'h5A5A);
    end

    // R10: write enable per legal code
    for (int c = 4; c < 16; c++) begin
      apply(4'(c), 8'h3C, 8'hC3, 16'h0000);
      chk("R10 write enable map", 32'(dst_we),
          32'((c != 9) && (c != 10) && (c != 11)));
      chk("R8 legal codes not illegal", 32'(illegal_op), 0);
    end

    // R1: reset mid-run clears outputs
    apply(4'd13, 8'hF0, 8'h0F, 16'hFFFF);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset res_val", 32'(res_val), 0);
    chk("R1 async reset stat_out", 32'(stat_out), 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule